// File: doc/BRIEF.md
# Hamming ECC syndrome corrector

This block checks one 512-byte segment after a page read. It takes two 24-bit Hamming codes. The first is the code as it sits in the spare area, stored in inverted form. The second is the code the datapath has just calculated over the segment. The block splits the difference between the two codes into two 12-bit syndromes and sorts the result into four classes: clean, one flipped data bit, one flipped bit in the code itself, or beyond repair.

When exactly one data bit is wrong, the block reports its byte index and bit index. It then repairs the segment buffer in place. It does this with one read-modify-write of the affected byte, through a simple buffer port whose read data arrives one cycle after the read strobe. A single-cycle done pulse ends every check, and the status and location outputs hold their values until the next check starts.

Top module: `ecc_syndrome_fixer`

## Requirements
- R1: Each 24-bit code is split into two 12-bit halves. Bits [11:0] form the low half: byte 0 plus the low nibble of byte 1. Bits [23:12] form the high half: the high nibble of byte 1 plus byte 2.
- R2: The stored code is bitwise inverted before it is compared. Feeding the stored code in uninverted form, equal to the calculated code, yields status 3.
- R3: The odd syndrome is the XOR of the two low halves, and the even syndrome is the XOR of the two high halves. When both syndromes are zero, the status is 0 (clean), the reported location is 0, and the buffer is neither read nor written.
- R4: When the odd syndrome equals the 12-bit complement of the even syndrome, the status is 1 (data bit corrected). The reported byte index is odd[11:3] and the reported bit index is odd[2:0]. This holds at the extremes: byte 0 bit 0, and byte 511 bit 7.
- R5: For status 1, the block performs exactly one read and then one write at the reported byte index. The written byte equals the read byte with the reported bit inverted, and the write completes before done.
- R6: When the OR of the two syndromes has exactly one bit set, the status is 2 (code bit corrected). The buffer is not written and the data are unchanged.
- R7: Every other syndrome pattern gives status 3 (uncorrectable), with no buffer write.
- R8: done is a one-cycle pulse. Count cycles from the clock edge that samples start. For status 0, 2 or 3, done is high in the cycle after the second edge. For status 1, done is high in the cycle after the fourth edge.
- R9: start is ignored while a check is in progress. It causes no second done and no second write.
- R10: After reset, done, buf_rd_en and buf_wr_en are low, and status reads 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Begin a check; sampled only when idle |
| stored_code | input | 24 | Code as held in the spare area (inverted form) |
| calc_code | input | 24 | Code calculated over the segment |
| buf_addr | output | 9 | Byte index for buffer access |
| buf_rd_en | output | 1 | Buffer read strobe; data expected one cycle later |
| buf_rdata | input | 8 | Buffer read data |
| buf_wr_en | output | 1 | Buffer write strobe |
| buf_wdata | output | 8 | Corrected byte to write |
| done | output | 1 | One-cycle end-of-check pulse |
| status | output | 2 | 0 clean, 1 data fixed, 2 code fixed, 3 uncorrectable |
| err_byte | output | 9 | Byte index of the corrected data bit |
| err_bit | output | 3 | Bit index of the corrected data bit |

## Verification
The hardest situations to reach are the edges of the complement rule. Those are an all-zero odd syndrome paired with an all-ones even syndrome, and the reverse. Others are a lone flipped bit in either code half, and a start pulse that arrives in the middle of a read-modify-write. The stimulus does not search for codes with these properties. It picks the two syndromes it wants and XORs them into a calculated code to form the true stored code. It inverts that code before applying it. To test the busy case, it re-pulses start one cycle after launching a correction, then counts done pulses and compares the buffer contents against a single expected bit flip.

// File: rtl/ecc_fix_pkg.sv
package ecc_fix_pkg;

    typedef enum logic [1:0] {
        ST_CLEAN      = 2'd0,
        ST_DATA_FIXED = 2'd1,
        ST_CODE_FIXED = 2'd2,
        ST_UNCORR     = 2'd3
    } fix_status_e;

    typedef enum logic [2:0] {
        PH_IDLE   = 3'd0,
        PH_EVAL   = 3'd1,
        PH_READ   = 3'd2,
        PH_WRITE  = 3'd3,
        PH_FINISH = 3'd4
    } phase_e;

endpackage

// File: rtl/ecc_code_unpack.sv
module ecc_code_unpack #(
    parameter int HALF_W        = 12,
    parameter bit INVERT_STORED = 1'b1,
    localparam int CODE_W       = 2 * HALF_W
) (
    input  logic [CODE_W-1:0] stored_raw,
    input  logic [CODE_W-1:0] calc,
    output logic [HALF_W-1:0] syn_odd,
    output logic [HALF_W-1:0] syn_even
);
    logic [CODE_W-1:0] stored_true;

    generate
        if (INVERT_STORED) begin : g_inv
            assign stored_true = ~stored_raw;
        end else begin : g_plain
            assign stored_true = stored_raw;
        end
    endgenerate

    // Low half: byte0 plus low nibble of byte1; high half: the rest.
    logic [HALF_W-1:0] st_lo, st_hi, ca_lo, ca_hi;
    assign st_lo = stored_true[HALF_W-1:0];
    assign st_hi = stored_true[CODE_W-1:HALF_W];
    assign ca_lo = calc[HALF_W-1:0];
    assign ca_hi = calc[CODE_W-1:HALF_W];

    assign syn_odd  = st_lo ^ ca_lo;
    assign syn_even = st_hi ^ ca_hi;
endmodule

// File: rtl/syndrome_classify.sv
module syndrome_classify
    import ecc_fix_pkg::*;
#(
    parameter int SEG_ADDR_W = 9,
    parameter int BIT_IDX_W  = 3,
    localparam int HALF_W    = SEG_ADDR_W + BIT_IDX_W
) (
    input  logic [HALF_W-1:0]     syn_odd,
    input  logic [HALF_W-1:0]     syn_even,
    output fix_status_e           cls_status,
    output logic [SEG_ADDR_W-1:0] cls_byte,
    output logic [BIT_IDX_W-1:0]  cls_bit
);
    logic [HALF_W-1:0] merged;
    logic              is_zero, is_compl, is_single;

    assign merged    = syn_odd | syn_even;
    assign is_zero   = (merged == '0);
    assign is_compl  = (syn_odd == ~syn_even);
    assign is_single = !is_zero && ((merged & (merged - HALF_W'(1))) == '0);

    always_comb begin
        cls_byte = '0;
        cls_bit  = '0;
        if (is_zero) begin
            cls_status = ST_CLEAN;
        end else if (is_compl) begin
            cls_status = ST_DATA_FIXED;
            cls_byte   = syn_odd[HALF_W-1:BIT_IDX_W];
            cls_bit    = syn_odd[BIT_IDX_W-1:0];
        end else if (is_single) begin
            cls_status = ST_CODE_FIXED;
        end else begin
            cls_status = ST_UNCORR;
        end
    end
endmodule

// File: rtl/ecc_syndrome_fixer.sv
module ecc_syndrome_fixer
    import ecc_fix_pkg::*;
#(
    parameter int  SEG_BYTES     = 512,
    parameter bit  INVERT_STORED = 1'b1,
    localparam int BYTE_W        = 8,
    localparam int BIT_IDX_W     = $clog2(BYTE_W),
    localparam int SEG_ADDR_W    = $clog2(SEG_BYTES),
    localparam int HALF_W        = SEG_ADDR_W + BIT_IDX_W,
    localparam int CODE_W        = 2 * HALF_W
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  start,
    input  logic [CODE_W-1:0]     stored_code,
    input  logic [CODE_W-1:0]     calc_code,
    output logic [SEG_ADDR_W-1:0] buf_addr,
    output logic                  buf_rd_en,
    input  logic [BYTE_W-1:0]     buf_rdata,
    output logic                  buf_wr_en,
    output logic [BYTE_W-1:0]     buf_wdata,
    output logic                  done,
    output logic [1:0]            status,
    output logic [SEG_ADDR_W-1:0] err_byte,
    output logic [BIT_IDX_W-1:0]  err_bit
);
    typedef struct packed {
        phase_e                phase;
        logic [CODE_W-1:0]     stored;
        logic [CODE_W-1:0]     calc;
        fix_status_e           stat;
        logic [SEG_ADDR_W-1:0] loc_byte;
        logic [BIT_IDX_W-1:0]  loc_bit;
    } fixer_state_t;

    fixer_state_t state_d, state_q;

    logic [HALF_W-1:0]     syn_odd, syn_even;
    fix_status_e           cls_status;
    logic [SEG_ADDR_W-1:0] cls_byte;
    logic [BIT_IDX_W-1:0]  cls_bit;

    ecc_code_unpack #(
        .HALF_W        (HALF_W),
        .INVERT_STORED (INVERT_STORED)
    ) u_unpack (
        .stored_raw (state_q.stored),
        .calc       (state_q.calc),
        .syn_odd    (syn_odd),
        .syn_even   (syn_even)
    );

    syndrome_classify #(
        .SEG_ADDR_W (SEG_ADDR_W),
        .BIT_IDX_W  (BIT_IDX_W)
    ) u_classify (
        .syn_odd    (syn_odd),
        .syn_even   (syn_even),
        .cls_status (cls_status),
        .cls_byte   (cls_byte),
        .cls_bit    (cls_bit)
    );

    always_comb begin
        state_d = state_q;
        unique case (state_q.phase)
            PH_IDLE: begin
                if (start) begin
                    state_d.stored = stored_code;
                    state_d.calc   = calc_code;
                    state_d.phase  = PH_EVAL;
                end
            end
            PH_EVAL: begin
                state_d.stat     = cls_status;
                state_d.loc_byte = cls_byte;
                state_d.loc_bit  = cls_bit;
                state_d.phase    = (cls_status == ST_DATA_FIXED) ? PH_READ : PH_FINISH;
            end
            PH_READ:   state_d.phase = PH_WRITE;
            PH_WRITE:  state_d.phase = PH_FINISH;
            PH_FINISH: state_d.phase = PH_IDLE;
            default:   state_d.phase = PH_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= '{phase: PH_IDLE, stored: '0, calc: '0, stat: ST_CLEAN,
                         loc_byte: '0, loc_bit: '0};
        end else begin
            state_q <= state_d;
        end
    end

    assign buf_addr  = state_q.loc_byte;
    assign buf_rd_en = (state_q.phase == PH_READ);
    assign buf_wr_en = (state_q.phase == PH_WRITE);
    assign buf_wdata = buf_rdata ^ (BYTE_W'(1) << state_q.loc_bit);
    assign done      = (state_q.phase == PH_FINISH);
    assign status    = state_q.stat;
    assign err_byte  = state_q.loc_byte;
    assign err_bit   = state_q.loc_bit;

    // R5
    wr_follows_rd_chk: assert property (@(posedge clk) disable iff (!rst_n)
        buf_wr_en |-> $past(buf_rd_en));
    // R5
    wr_addr_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
        buf_wr_en |-> $stable(buf_addr));
    // R5
    fix_done_after_wr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (done && status == ST_DATA_FIXED) |-> $past(buf_wr_en));
    // R6
    wr_only_data_fix_chk: assert property (@(posedge clk) disable iff (!rst_n)
        buf_wr_en |-> (status == ST_DATA_FIXED));
    // R8
    done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);
    // R9
    strobe_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({buf_rd_en, buf_wr_en, done}));
endmodule

// File: tb/tb_ecc_syndrome_fixer.sv
module tb_ecc_syndrome_fixer;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic [23:0] stored_code = '0;
    logic [23:0] calc_code = '0;
    logic [8:0]  buf_addr;
    logic        buf_rd_en, buf_wr_en, done;
    logic [7:0]  buf_rdata = '0;
    logic [7:0]  buf_wdata;
    logic [1:0]  status;
    logic [8:0]  err_byte;
    logic [2:0]  err_bit;

    int checks = 0;
    int fails  = 0;
    int rd_cnt = 0;
    int wr_cnt = 0;
    int done_cnt = 0;
    logic [7:0] mem [512];

    always #5 clk = ~clk;

    ecc_syndrome_fixer dut (
        .clk(clk), .rst_n(rst_n), .start(start),
        .stored_code(stored_code), .calc_code(calc_code),
        .buf_addr(buf_addr), .buf_rd_en(buf_rd_en), .buf_rdata(buf_rdata),
        .buf_wr_en(buf_wr_en), .buf_wdata(buf_wdata),
        .done(done), .status(status), .err_byte(err_byte), .err_bit(err_bit)
    );

    always @(posedge clk) begin
        if (buf_rd_en) begin buf_rdata <= mem[buf_addr]; rd_cnt <= rd_cnt + 1; end
        if (buf_wr_en) begin mem[buf_addr] <= buf_wdata; wr_cnt <= wr_cnt + 1; end
        if (done) done_cnt <= done_cnt + 1;
    end

    function automatic logic [7:0] seed(input int i);
        return 8'(i) ^ 8'h5A;
    endfunction

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // Build stored (inverted) code from calc code and desired syndromes.
    function automatic logic [23:0] make_stored(input logic [23:0] calc,
                                                input logic [11:0] odd,
                                                input logic [11:0] even);
        return ~(calc ^ {even, odd});
    endfunction

    // Launch one check, return latency (negedges until done) and status.
    task automatic run(input logic [23:0] calc, input logic [23:0] stored,
                       output int lat, output logic [1:0] st);
        @(negedge clk);
        calc_code = calc; stored_code = stored; start = 1'b1;
        lat = 0;
        @(negedge clk); start = 1'b0; lat = 1;
        while (!done && lat < 20) begin @(negedge clk); lat++; end
        st = status;
        @(negedge clk);
        check("R8 pulse width", {31'd0, done}, 32'd0);
    endtask

    task automatic t_reset;
        check("R10 done", {31'd0, done}, 0);
        check("R10 rd_en", {31'd0, buf_rd_en}, 0);
        check("R10 wr_en", {31'd0, buf_wr_en}, 0);
        check("R10 status", {30'd0, status}, 0);
    endtask

    task automatic t_clean;
        int lat; logic [1:0] st; int r0, w0;
        r0 = rd_cnt; w0 = wr_cnt;
        run(24'h3C9A17, make_stored(24'h3C9A17, 12'h0, 12'h0), lat, st);
        check("R3 status", {30'd0, st}, 0);
        check("R3 location", {20'd0, err_byte, err_bit}, 0);
        check("R3 no access", rd_cnt - r0 + wr_cnt - w0, 0);
        check("R8 latency plain", lat, 2);
    endtask

    task automatic t_data(input logic [8:0] b, input logic [2:0] k, input logic [23:0] calc);
        int lat; logic [1:0] st; int r0, w0; logic [7:0] orig, nb;
        logic [11:0] odd;
        odd = {b, k};
        orig = mem[b]; nb = mem[b ^ 9'd1];
        r0 = rd_cnt; w0 = wr_cnt;
        run(calc, make_stored(calc, odd, ~odd), lat, st);
        check("R4 status", {30'd0, st}, 1);
        check("R4 byte", {23'd0, err_byte}, {23'd0, b});
        check("R4 bit", {29'd0, err_bit}, {29'd0, k});
        check("R5 flipped", {24'd0, mem[b]}, {24'd0, orig ^ (8'd1 << k)});
        check("R5 neighbour", {24'd0, mem[b ^ 9'd1]}, {24'd0, nb});
        check("R5 one read", rd_cnt - r0, 1);
        check("R5 one write", wr_cnt - w0, 1);
        check("R8 latency fix", lat, 4);
    endtask

    task automatic t_code(input logic [11:0] odd, input logic [11:0] even);
        int lat; logic [1:0] st; int w0;
        w0 = wr_cnt;
        run(24'hA5F00F, make_stored(24'hA5F00F, odd, even), lat, st);
        check("R6 status", {30'd0, st}, 2);
        check("R6 no write", wr_cnt - w0, 0);
        check("R6 data intact", {24'd0, mem[9'd5]}, {24'd0, seed(5)});
    endtask

    task automatic t_uncorr(input logic [11:0] odd, input logic [11:0] even);
        int lat; logic [1:0] st; int w0;
        w0 = wr_cnt;
        run(24'h123456, make_stored(24'h123456, odd, even), lat, st);
        check("R7 status", {30'd0, st}, 3);
        check("R7 no write", wr_cnt - w0, 0);
    endtask

    task automatic t_inversion;
        int lat; logic [1:0] st;
        run(24'h0F0F33, 24'h0F0F33, lat, st);
        check("R2 uninverted gives 3", {30'd0, st}, 3);
        run(24'h0F0F33, ~24'h0F0F33, lat, st);
        check("R2 inverted gives 0", {30'd0, st}, 0);
    endtask

    task automatic t_unpack;
        int lat; logic [1:0] st;
        // Differences only in byte1 low nibble bit 8 (odd) and byte2 bit 23 (even): two bits -> 3.
        // Single difference at bit 12 (byte1 high nibble, even half bit 0) -> code error.
        run(24'h000000, ~24'h001000, lat, st);
        check("R1 byte1 high nibble in even half", {30'd0, st}, 2);
        // odd = 0x100 (byte1 bit0), even = ~0x100 -> data error at byte 0x20 bit 0.
        run(24'h000000, ~{12'hEFF, 12'h100}, lat, st);
        check("R1 byte1 low nibble in odd half", {23'd0, err_byte}, 32'h20);
    endtask

    task automatic t_busy;
        int d0, w0; logic [7:0] orig;
        logic [11:0] odd;
        odd = {9'd77, 3'd6};
        orig = mem[77]; d0 = done_cnt; w0 = wr_cnt;
        @(negedge clk);
        calc_code = 24'h55AA55; stored_code = make_stored(24'h55AA55, odd, ~odd); start = 1'b1;
        @(negedge clk); start = 1'b0;
        @(negedge clk); start = 1'b1;
        calc_code = 24'h0; stored_code = ~24'h0;
        @(negedge clk); start = 1'b0;
        repeat (6) @(negedge clk);
        check("R9 single done", done_cnt - d0, 1);
        check("R9 single write", wr_cnt - w0, 1);
        check("R9 flipped once", {24'd0, mem[77]}, {24'd0, orig ^ 8'h40});
    endtask

    initial begin
        for (int i = 0; i < 512; i++) mem[i] = seed(i);
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        @(negedge clk);
        t_clean();
        t_data(9'h0A5, 3'd3, 24'h9E2B41);
        t_data(9'd511, 3'd7, 24'h000000);
        t_data(9'd0, 3'd0, 24'hFFFFFF);
        t_code(12'h000, 12'h080);
        t_code(12'h800, 12'h000);
        t_uncorr(12'h003, 12'h000);
        t_uncorr(12'h0F0, 12'h00F);
        t_inversion();
        t_unpack();
        t_busy();
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        #1_000_000;
        checks++; fails++;
        $display("FAIL watchdog expired actual=hung expected=finished");
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule